// File: doc/BRIEF.md
# Time-Slotted Serial Receiver with Watermark FIFO

This block is the receive half of a synchronous serial port that carries fixed 16-bit slots back to back, with a frame sync pulse marking the first slot of each frame. It samples the bit clock, frame sync and serial data lines in the system clock domain and acts on each falling bit-clock edge. It assembles each word MSB first and stores it in an eight-entry receive queue, which the host drains one word per read pulse.

Software picks how far the queue must fill before it is reported as full enough to service. The receive interrupt fires only when that watermark flag, the interrupt enable and the queue enable are all set. With the queue disabled, the receiver holds a single word and reports it through a data-present flag. A frame flag shows whether the slot now arriving is the first slot of its frame.

Top module: `sync_serial_rx`

## Requirements
- R1: Serial data is sampled on each falling edge of `sclk_in`. A word starts at a falling edge where `fsync_in` is 1, and that bit is the MSB. Slots of 16 bits follow one another with no gap. Words are read out in the order they arrived, with all 16 bits intact.
- R2: `stat_dfull` stays 0 through the system-clock edge that samples the last bit of a word. It is 1 after the next edge. This applies when the receiver was empty.
- R3: With the queue enabled, `stat_wm` is 1 while the number of stored words is at or above the watermark, and 0 while it is below.
- R4: The watermark `cfg_wmark` (4 bits) is used as given for the values 1 to 8. A value of 0 acts as 1, and values from 9 to 15 act as 8.
- R5: `stat_wm` is 0 whenever `cfg_fifo_en` is 0, whatever the queue holds.
- R6: Once the queue holds 8 words, every further word is discarded until the host reads. The 8 words already stored are unchanged.
- R7: A one-cycle `rd_en` pulse pops one word, which appears on `rd_data` after that clock edge. A read of an empty receiver leaves `rd_data` at the last popped value and leaves the receiver empty.
- R8: `rx_irq` is 1 exactly when `stat_wm`, `cfg_irq_en` and `cfg_fifo_en` are all 1.
- R9: `stat_rfs` goes to 1 once the first bit of a frame's first slot is sampled. It returns to 0 once the first bit of the next slot is sampled. It is 0 after reset.
- R10: With `cfg_fifo_en` at 0, the receiver holds at most one word. `stat_dfull` goes to 1 when a word arrives and to 0 when the host reads it. A word that arrives while one is already held is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial bit clock, sampled by `clk` |
| fsync_in | input | 1 | Frame sync, high during the MSB of the first slot |
| sdata_in | input | 1 | Serial receive data |
| rd_en | input | 1 | One-cycle read pulse that pops a word |
| rd_data | output | 16 | Last word popped |
| cfg_fifo_en | input | 1 | 1 selects the 8-entry queue, 0 selects single-word mode |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| cfg_wmark | input | 4 | Watermark level |
| stat_rfs | output | 1 | Current slot is the first slot of the frame |
| stat_wm | output | 1 | Fill level has reached the watermark |
| stat_dfull | output | 1 | At least one word is waiting |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A wrong fill count shows at the ports within one read or one write. `stat_wm` and `rx_irq` flip at the wrong word count, and `stat_dfull` drops early or stays high after the last pop. Pointer faults surface as reordered or repeated words on `rd_data` the first time the queue wraps. Bit-counter faults corrupt the very first assembled word. A stuck first-slot marker shows on `stat_rfs` at the start of the second slot.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned SSRX_WORD_W = 16;
  localparam int unsigned SSRX_DEPTH  = 8;
  localparam int unsigned SSRX_WM_W   = 4;
endpackage

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fsync,
  input  logic              sdata,
  output logic              word_stb,
  output logic [WORD_W-1:0] word,
  output logic              first_slot
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);

  logic              sclk_d;
  logic              active_q, active_n;
  logic [CW-1:0]     bcnt_q, bcnt_n;
  logic [WORD_W-1:0] shreg_q, shreg_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              stb_q, stb_n;
  logic              rfs_q, rfs_n;
  logic              fall;

  assign fall = sclk_d & ~sclk;

  always_comb begin
    active_n = active_q;
    bcnt_n   = bcnt_q;
    shreg_n  = shreg_q;
    word_n   = word_q;
    stb_n    = 1'b0;
    rfs_n    = rfs_q;
    if (fall) begin
      if (fsync) begin
        active_n = 1'b1;
        shreg_n  = {shreg_q[WORD_W-2:0], sdata};
        bcnt_n   = CW'(1);
        rfs_n    = 1'b1;
      end else if (active_q) begin
        shreg_n = {shreg_q[WORD_W-2:0], sdata};
        if (bcnt_q == '0) begin
          rfs_n = 1'b0;
        end
        if (bcnt_q == LAST_BIT) begin
          stb_n  = 1'b1;
          word_n = {shreg_q[WORD_W-2:0], sdata};
          bcnt_n = '0;
        end else begin
          bcnt_n = bcnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      active_q <= 1'b0;
      bcnt_q   <= '0;
      shreg_q  <= '0;
      word_q   <= '0;
      stb_q    <= 1'b0;
      rfs_q    <= 1'b0;
    end else begin
      sclk_d   <= sclk;
      active_q <= active_n;
      bcnt_q   <= bcnt_n;
      shreg_q  <= shreg_n;
      word_q   <= word_n;
      stb_q    <= stb_n;
      rfs_q    <= rfs_n;
    end
  end

  assign word_stb   = stb_q;
  assign word       = word_q;
  assign first_slot = rfs_q;
endmodule

// File: rtl/ssrx_queue.sv
module ssrx_queue #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             multi_en,
  input  logic                             push,
  input  logic [WIDTH-1:0]                 push_data,
  input  logic                             pop,
  output logic [WIDTH-1:0]                 pop_data,
  output logic [$clog2(DEPTH+1)-1:0]       level
);
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LW-1:0]    lvl_q, lvl_n, cap;
  logic [WIDTH-1:0] dout_q, dout_n;
  logic             accept, take;

  assign cap    = multi_en ? LW'(DEPTH) : LW'(1);
  assign accept = push & (lvl_q < cap);
  assign take   = pop & (lvl_q != '0);

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    dout_n = dout_q;
    lvl_n  = lvl_q;
    if (accept) begin
      wptr_n = (wptr_q == PTR_LAST) ? '0 : wptr_q + PW'(1);
    end
    if (take) begin
      rptr_n = (rptr_q == PTR_LAST) ? '0 : rptr_q + PW'(1);
      dout_n = mem[rptr_q];
    end
    case ({accept, take})
      2'b10:   lvl_n = lvl_q + LW'(1);
      2'b01:   lvl_n = lvl_q - LW'(1);
      default: lvl_n = lvl_q;
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && (wptr_q == PW'(g))) begin
        mem[g] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      dout_q <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      lvl_q  <= lvl_n;
      dout_q <= dout_n;
    end
  end

  assign pop_data = dout_q;
  assign level    = lvl_q;
endmodule

// File: rtl/ssrx_status.sv
module ssrx_status #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WM_W  = 4
) (
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [WM_W-1:0]            wmark,
  input  logic                       multi_en,
  input  logic                       irq_en,
  output logic                       wm_flag,
  output logic                       data_full,
  output logic                       irq
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [LW-1:0] wm_eff;

  always_comb begin
    if (wmark == '0) begin
      wm_eff = LW'(1);
    end else if (int'(wmark) > int'(DEPTH)) begin
      wm_eff = LW'(DEPTH);
    end else begin
      wm_eff = LW'(wmark);
    end
  end

  assign wm_flag   = multi_en & (level >= wm_eff);
  assign data_full = (level != '0);
  assign irq       = wm_flag & irq_en & multi_en;
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import ssrx_pkg::*;
#(
  parameter int unsigned WORD_W = SSRX_WORD_W,
  parameter int unsigned DEPTH  = SSRX_DEPTH,
  parameter int unsigned WM_W   = SSRX_WM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  input  logic              cfg_fifo_en,
  input  logic              cfg_irq_en,
  input  logic [WM_W-1:0]   cfg_wmark,
  output logic              stat_rfs,
  output logic              stat_wm,
  output logic              stat_dfull,
  output logic              rx_irq
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              push;
  logic [WORD_W-1:0] push_word;
  logic [LW-1:0]     fill_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  ssrx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sclk       (sclk_in),
    .fsync      (fsync_in),
    .sdata      (sdata_in),
    .word_stb   (push),
    .word       (push_word),
    .first_slot (stat_rfs)
  );

  ssrx_queue #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .multi_en  (cfg_fifo_en),
    .push      (push),
    .push_data (push_word),
    .pop       (rd_en),
    .pop_data  (rd_data),
    .level     (fill_lvl)
  );

  ssrx_status #(.DEPTH(DEPTH), .WM_W(WM_W)) u_stat (
    .level     (fill_lvl),
    .wmark     (cfg_wmark),
    .multi_en  (cfg_fifo_en),
    .irq_en    (cfg_irq_en),
    .wm_flag   (stat_wm),
    .data_full (stat_dfull),
    .irq       (rx_irq)
  );
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_en,
  input logic [WORD_W-1:0]          rd_data,
  input logic                       cfg_fifo_en,
  input logic                       cfg_irq_en,
  input logic                       stat_wm,
  input logic                       rx_irq,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] fill_lvl
);
  AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (stat_wm && cfg_irq_en && cfg_fifo_en)); // R8

  AST_WM_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_en |-> !stat_wm); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= ($clog2(DEPTH+1))'(DEPTH)); // R6

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill_lvl == '0) |=> ($stable(rd_data) && fill_lvl == '0)); // R7

  AST_SINGLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && fill_lvl != '0 && push && !rd_en) |=> (fill_lvl == $past(fill_lvl))); // R10
endmodule

bind sync_serial_rx sync_serial_rx_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .cfg_fifo_en (cfg_fifo_en),
  .cfg_irq_en  (cfg_irq_en),
  .stat_wm     (stat_wm),
  .rx_irq      (rx_irq),
  .push        (push),
  .fill_lvl    (fill_lvl)
);

// File: tb/sync_serial_rx_tb_top.sv
`timescale 1ns/1ps
module sync_serial_rx_tb_top;
  logic        clk;
  logic        rst_n;
  logic        sclk_in, fsync_in, sdata_in, rd_en;
  logic [15:0] rd_data;
  logic        cfg_fifo_en, cfg_irq_en;
  logic [3:0]  cfg_wmark;
  logic        stat_rfs, stat_wm, stat_dfull, rx_irq;

  int total = 0;
  int bad   = 0;
  logic rfs_mid;
  logic [15:0] got;

  sync_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .fsync_in(fsync_in),
    .sdata_in(sdata_in), .rd_en(rd_en), .rd_data(rd_data),
    .cfg_fifo_en(cfg_fifo_en), .cfg_irq_en(cfg_irq_en), .cfg_wmark(cfg_wmark),
    .stat_rfs(stat_rfs), .stat_wm(stat_wm), .stat_dfull(stat_dfull), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w, input logic fs, input logic tchk);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      sdata_in = w[i];
      fsync_in = fs && (i == 15);
      sclk_in  = 1'b0;
      @(negedge clk);
      if (i == 8) rfs_mid = stat_rfs;
      if (tchk && i == 0) chk("R2 not yet stored", {15'd0, stat_dfull}, 16'd0);
      @(negedge clk);
      if (tchk && i == 0) chk("R2 stored next edge", {15'd0, stat_dfull}, 16'd1);
      sclk_in  = 1'b1;
      fsync_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pop(output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic drain();
    logic [15:0] d;
    for (int k = 0; k < 10; k++) pop(d);
  endtask

  task automatic t_reset();
    chk("R7 reset rd_data", rd_data, 16'h0000);
    chk("R10 reset dfull", {15'd0, stat_dfull}, 16'd0);
    chk("R9 reset rfs", {15'd0, stat_rfs}, 16'd0);
    chk("R8 reset irq", {15'd0, rx_irq}, 16'd0);
  endtask

  task automatic t_order();
    cfg_fifo_en = 1; cfg_wmark = 8;
    send_word(16'hA5C3, 1, 1);
    send_word(16'h1234, 0, 0);
    send_word(16'h8001, 0, 0);
    pop(got); chk("R1 first word", got, 16'hA5C3);
    pop(got); chk("R1 second word", got, 16'h1234);
    pop(got); chk("R1 third word", got, 16'h8001);
  endtask

  task automatic t_rfs();
    send_word(16'h0F0F, 1, 0);
    chk("R9 set in slot 0", {15'd0, rfs_mid}, 16'd1);
    send_word(16'hF0F0, 0, 0);
    chk("R9 clear in slot 1", {15'd0, rfs_mid}, 16'd0);
    drain();
  endtask

  task automatic t_watermark();
    cfg_fifo_en = 1; cfg_wmark = 3;
    send_word(16'h0001, 1, 0);
    send_word(16'h0002, 0, 0);
    chk("R3 below mark", {15'd0, stat_wm}, 16'd0);
    send_word(16'h0003, 0, 0);
    chk("R3 at mark", {15'd0, stat_wm}, 16'd1);
    pop(got);
    chk("R3 back below", {15'd0, stat_wm}, 16'd0);
    drain();
  endtask

  task automatic t_clamp();
    cfg_wmark = 0;
    send_word(16'h1111, 1, 0);
    chk("R4 zero acts as one", {15'd0, stat_wm}, 16'd1);
    drain();
    cfg_wmark = 15;
    for (int k = 0; k < 7; k++) send_word(16'h2000 + 16'(k), (k == 0), 0);
    chk("R4 large at seven", {15'd0, stat_wm}, 16'd0);
    send_word(16'h2007, 0, 0);
    chk("R4 large acts as eight", {15'd0, stat_wm}, 16'd1);
  endtask

  task automatic t_irq();
    cfg_wmark = 2; cfg_irq_en = 0;
    #1;
    chk("R8 irq masked", {15'd0, rx_irq}, 16'd0);
    cfg_irq_en = 1;
    #1;
    chk("R8 irq all set", {15'd0, rx_irq}, 16'd1);
    cfg_fifo_en = 0;
    #1;
    chk("R8 irq queue off", {15'd0, rx_irq}, 16'd0);
    chk("R5 flag off", {15'd0, stat_wm}, 16'd0);
    cfg_fifo_en = 1; cfg_irq_en = 0;
    drain();
  endtask

  task automatic t_overflow();
    cfg_fifo_en = 1; cfg_wmark = 8;
    for (int k = 0; k < 10; k++) send_word(16'hC000 + 16'(k), (k == 0), 0);
    for (int k = 0; k < 8; k++) begin
      pop(got);
      chk("R6 kept word", got, 16'hC000 + 16'(k));
    end
    chk("R6 extras dropped", {15'd0, stat_dfull}, 16'd0);
  endtask

  task automatic t_empty_read();
    pop(got);
    chk("R7 empty read holds", got, 16'hC007);
    chk("R7 still empty", {15'd0, stat_dfull}, 16'd0);
    send_word(16'h5A5A, 1, 0);
    pop(got);
    chk("R7 next word", got, 16'h5A5A);
    chk("R7 one entry only", {15'd0, stat_dfull}, 16'd0);
  endtask

  task automatic t_single();
    cfg_fifo_en = 0;
    send_word(16'h7E01, 1, 0);
    chk("R10 word held", {15'd0, stat_dfull}, 16'd1);
    send_word(16'h7E02, 0, 0);
    pop(got);
    chk("R10 first kept", got, 16'h7E01);
    chk("R10 cleared by read", {15'd0, stat_dfull}, 16'd0);
    pop(got);
    chk("R10 second dropped", got, 16'h7E01);
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; sclk_in = 1; fsync_in = 0; sdata_in = 0; rd_en = 0;
    cfg_fifo_en = 1; cfg_irq_en = 0; cfg_wmark = 8; rfs_mid = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_rfs();
    t_watermark();
    t_clamp();
    t_irq();
    t_overflow();
    t_empty_read();
    t_single();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule